// File: doc/BRIEF.md
# Compare-match timer channel

This block is one channel of a memory-mapped interval timer. It has an up-counter, a compare register and a 16-bit control/status register. It also holds a 16-bit start register that several channels can share; this channel owns one bit of it. While that run bit is set, the counter advances once per prescaled clock tick. When the count equals the compare value at a tick, the counter returns to zero, sets a match flag and, if enabled, raises the interrupt line. The period is therefore compare+1 ticks.

Software uses the channel in one of two ways. It can program a compare value and take periodic interrupts. It can also leave the counter free-running and read it as a time base, using the match flag as a wrap indicator. The `CNT_W` parameter selects one of two register widths: 16 bits or 32 bits. Writes to the counter reach the running count only after a modelled synchronisation delay of `SYNC_CYC` clocks.

Top module: `cmt_channel`

## Requirements
- R1: The channel window has three registers selected by index: control/status = 0, counter = 1, compare = 2. The byte address is the index times 2 when `CNT_W`=16 and the index times 4 when `CNT_W`=32. Read data appears on `rdata` in the clock after the cycle in which `rd_en` is sampled. All registers reset to 0, except compare, which resets to all ones.
- R2: Control/status is 16 bits wide in both variants, and its upper 16 read bits are zero. In the 16-bit variant, bit 7 is the match flag, bit 6 is the interrupt enable and bits 1:0 pick the divider: 0 gives /8, 1 gives /32, 2 gives /128 and 3 gives /512. In the 32-bit variant, bit 15 is the match flag, bit 14 is the max-wrap flag and bit 5 is the interrupt enable. Bits 2:0 of value 4, 5, 6 or 7 give /8, /32, /128 or /512; values 0 to 3 give one tick per clock. All other bits read back as written.
- R3: The start register (`st_sel`) is 16 bits and reads back as written. Bit `RUN_BIT` (default 0) runs the channel. The other bits do not start this channel. While the run bit is clear, the count holds.
- R4: At each tick the counter increments by one. If the count equals compare at that tick, the counter instead goes to 0 and the match flag is set, so the period is compare+1 ticks.
- R5: A control/status write clears a flag bit written as 0 and leaves a flag bit written as 1 unchanged. A hardware set of a flag in the same clock takes priority over the clear.
- R6: `irq` is high exactly while both the match flag and the interrupt enable are set. It stays high until software clears one of them; writing control/status as 0 drops it.
- R7: A counter write loads the count `SYNC_CYC` clocks after the write (default 2). A read issued in the clock right after the write still returns the old count.
- R8: Compare writes are truncated to `CNT_W` bits. Writing all ones gives the longest period.
- R9: If the count is above compare, the counter runs up to its all-ones value and then wraps to 0 without setting the match flag. In the 32-bit variant this wrap sets bit 14, and bit 14 never drives `irq`.
- R10: With a divider of /N selected, a running channel advances once every N clocks. The first tick comes on the Nth clock after the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel | input | 1 | Selects the channel register window |
| st_sel | input | 1 | Selects the shared start register (has priority over `ch_sel`) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address inside the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Several properties are checked every cycle by assertions:
- the wrap to zero on a match and the single-step increment between matches;
- the loading of the pending counter value on its due cycle;
- that a match flag only rises after a match;
- that the interrupt holds until a register write;
- that the prescaler never ticks on two consecutive clocks at a divided rate;
- that a stopped channel produces no ticks.

Other behaviour can only be shown by the bench's scenarios, which read the counter back after a known number of running clocks. These cover exact period lengths, the /8 and /512 divider spacing, the stale readback during the write delay, the wrap at all-ones without a match, and the write-0-to-clear flag semantics.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [1:0] {
    IDX_CTL  = 2'd0,
    IDX_CNT  = 2'd1,
    IDX_CMP  = 2'd2,
    IDX_NONE = 2'd3
  } cmt_idx_e;

  localparam int PRE_W = 9;

  // Returns log2 of the divider selected by the control word.
  function automatic logic [3:0] clk_shift(input logic [15:0] ctl, input logic wide);
    logic [1:0] s;
    s = ctl[1:0];
    if (wide && !ctl[2]) return 4'd0;
    return 4'd3 + {1'b0, s, 1'b0};
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [3:0] shift,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = ~({PRE_W{1'b1}} << shift);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R10: a divided rate never produces back-to-back ticks
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && shift != 4'd0) |=> (!tick || shift == 4'd0));

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W    = 32,
  parameter int SYNC_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match_hit,
  output logic             max_wrap
);

  localparam int SW = (SYNC_CYC < 1) ? 1 : $clog2(SYNC_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ld_now;
  logic [CNT_W-1:0] ld_data;

  generate
    if (SYNC_CYC == 0) begin : g_direct
      assign ld_now  = ld_req;
      assign ld_data = ld_val;
    end else begin : g_sync
      logic [SW-1:0]    left_q;
      logic [CNT_W-1:0] pend_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          left_q <= '0;
          pend_q <= '0;
        end else if (ld_req) begin
          left_q <= SW'(SYNC_CYC);
          pend_q <= ld_val;
        end else if (left_q != '0) begin
          left_q <= left_q - 1'b1;
        end
      end
      assign ld_now  = (left_q == SW'(1)) && !ld_req;
      assign ld_data = pend_q;
    end
  endgenerate

  always_comb begin
    match_hit = tick && !ld_now && (cnt_q == cmp_val);
    max_wrap  = tick && !ld_now && (cnt_q == {CNT_W{1'b1}}) && (cnt_q != cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (ld_now)                cnt_q <= ld_data;
    else if (match_hit || max_wrap) cnt_q <= '0;
    else if (tick)                  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R4: a match returns the count to zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> (cnt_q == '0));
  // R4: an ordinary tick adds exactly one
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_now && !match_hit && !max_wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: without a tick or a load the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_now) |=> $stable(cnt_q));
  // R7: a due load lands the pending value
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    ld_now |=> (cnt_q == $past(ld_data)));

endmodule

// File: rtl/cmt_csr.sv
module cmt_csr #(
  parameter bit WIDE = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        match_hit,
  input  logic        max_wrap,
  output logic [15:0] ctl,
  output logic        irq
);

  localparam int FLAG_BIT = WIDE ? 15 : 7;
  localparam int IE_BIT   = WIDE ? 5 : 6;

  logic [15:0] ctl_q, ctl_d;
  logic        irq_q;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d           = wdata;
      ctl_d[FLAG_BIT] = ctl_q[FLAG_BIT] & wdata[FLAG_BIT];
      if (WIDE) ctl_d[14] = ctl_q[14] & wdata[14];
    end
    if (match_hit)         ctl_d[FLAG_BIT] = 1'b1;
    if (WIDE && max_wrap)  ctl_d[14] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      irq_q <= ctl_d[FLAG_BIT] & ctl_d[IE_BIT];
    end
  end

  assign ctl = ctl_q;
  assign irq = irq_q;

  // R5: a hardware set wins over a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> ctl_q[FLAG_BIT]);
  // R4: the match flag only rises after a match
  a_r4_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[FLAG_BIT]) |-> $past(match_hit));
  // R6: the request holds until software writes
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr) |=> irq);

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SYNC_CYC = 2,
  parameter int RUN_BIT  = 0,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_sel,
  input  logic              st_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  localparam bit WIDE     = (CNT_W > 16);
  localparam int STRIDE_SH = WIDE ? 2 : 1;

  cmt_idx_e         idx;
  logic [15:0]      st_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      ctl;
  logic [31:0]      rdata_q;
  logic             run, tick, match_hit, max_wrap;
  logic             ctl_wr, cnt_wr, cmp_wr;

  always_comb begin
    idx    = cmt_idx_e'(addr[STRIDE_SH +: 2]);
    ctl_wr = wr_en && ch_sel && !st_sel && (idx == IDX_CTL);
    cnt_wr = wr_en && ch_sel && !st_sel && (idx == IDX_CNT);
    cmp_wr = wr_en && ch_sel && !st_sel && (idx == IDX_CMP);
    run    = st_q[RUN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      cmp_q <= '1;
    end else begin
      if (wr_en && st_sel) st_q <= wdata[15:0];
      if (cmp_wr)          cmp_q <= wdata[CNT_W-1:0];
    end
  end

  cmt_prescaler u_pre (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .shift (clk_shift(ctl, WIDE)),
    .tick  (tick)
  );

  cmt_counter #(.CNT_W(CNT_W), .SYNC_CYC(SYNC_CYC)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ld_req    (cnt_wr),
    .ld_val    (wdata[CNT_W-1:0]),
    .cmp_val   (cmp_q),
    .cnt       (cnt),
    .match_hit (match_hit),
    .max_wrap  (max_wrap)
  );

  cmt_csr #(.WIDE(WIDE)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .wdata     (wdata[15:0]),
    .match_hit (match_hit),
    .max_wrap  (max_wrap),
    .ctl       (ctl),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (st_sel) rdata_q <= {16'h0, st_q};
      else if (ch_sel) begin
        case (idx)
          IDX_CTL: rdata_q <= {16'h0, ctl};
          IDX_CNT: rdata_q <= 32'(cnt);
          IDX_CMP: rdata_q <= 32'(cmp_q);
          default: rdata_q <= '0;
        endcase
      end else rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

  // R2: control/status reads leave the upper half zero
  a_r2_ctl_upper: assert property (@(posedge clk) disable iff (rst)
    (rd_en && ch_sel && !st_sel && idx == IDX_CTL) |=> (rdata[31:16] == 16'h0));
  // R3: a stopped channel never ticks
  a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

endmodule

// File: tb/cmt_channel_test.sv
module cmt_channel_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  sel_ch, sel_st;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata32, rdata16;
  logic        irq32, irq16;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cmt_channel uut (
    .clk(clk), .rst(rst), .ch_sel(sel_ch[0]), .st_sel(sel_st[0]),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata32), .irq(irq32)
  );

  cmt_channel #(.CNT_W(16)) uut16 (
    .clk(clk), .rst(rst), .ch_sel(sel_ch[1]), .st_sel(sel_st[1]),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata16), .irq(irq16)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic bus_wr(input int d, input logic st, input logic [3:0] a, input logic [31:0] v);
    if (st) sel_st[d] = 1'b1; else sel_ch[d] = 1'b1;
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    sel_st = '0; sel_ch = '0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int d, input logic st, input logic [3:0] a, output logic [31:0] v);
    if (st) sel_st[d] = 1'b1; else sel_ch[d] = 1'b1;
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = (d == 1) ? rdata16 : rdata32;
    sel_st = '0; sel_ch = '0; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(0, 0, 4'd0, v); check("R1 reset ctl", v, 32'h0);
    bus_rd(0, 0, 4'd4, v); check("R1 reset cnt", v, 32'h0);
    bus_rd(0, 0, 4'd8, v); check("R1 R8 reset cmp", v, 32'hFFFF_FFFF);
    bus_rd(0, 1, 4'd0, v); check("R3 reset start", v, 32'h0);
    check("R6 reset irq", {31'h0, irq32}, 32'h0);
  endtask

  task automatic t_period;
    logic [31:0] v;
    bus_wr(0, 0, 4'd8, 32'd4);
    bus_wr(0, 0, 4'd0, 32'h0020);
    bus_wr(0, 1, 4'd0, 32'h1);
    repeat (6) @(negedge clk);
    bus_wr(0, 1, 4'd0, 32'h0);          // 7 ticks, period 5
    bus_rd(0, 0, 4'd4, v); check("R4 count after 7 ticks", v, 32'd2);
    bus_rd(0, 0, 4'd0, v); check("R4 R2 match flag bit15", v, 32'h8020);
    check("R6 irq on match", {31'h0, irq32}, 32'h1);
    bus_rd(0, 0, 4'd4, v); check("R3 stopped count holds", v, 32'd2);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    bus_wr(0, 0, 4'd0, 32'h8020);
    bus_rd(0, 0, 4'd0, v); check("R5 write 1 keeps flag", v, 32'h8020);
    check("R6 irq held", {31'h0, irq32}, 32'h1);
    bus_wr(0, 0, 4'd0, 32'h0020);
    bus_rd(0, 0, 4'd0, v); check("R5 write 0 clears flag", v, 32'h0020);
    check("R6 irq dropped", {31'h0, irq32}, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    bus_wr(0, 0, 4'd4, 32'd100);
    bus_rd(0, 0, 4'd4, v); check("R7 stale count after write", v, 32'd2);
    repeat (2) @(negedge clk);
    bus_rd(0, 0, 4'd4, v); check("R7 count loaded", v, 32'd100);
  endtask

  task automatic t_start_bits;
    logic [31:0] v;
    bus_wr(0, 1, 4'd0, 32'h00F0);
    bus_rd(0, 1, 4'd0, v); check("R3 start readback", v, 32'h00F0);
    repeat (5) @(negedge clk);
    bus_rd(0, 0, 4'd4, v); check("R3 other bits do not run", v, 32'd100);
  endtask

  task automatic t_wrap_max;
    logic [31:0] v;
    bus_wr(0, 0, 4'd4, 32'hFFFF_FFFC);
    repeat (3) @(negedge clk);
    bus_wr(0, 0, 4'd8, 32'd5);
    bus_wr(0, 0, 4'd0, 32'h0);
    bus_wr(0, 1, 4'd0, 32'h00F1);
    repeat (5) @(negedge clk);
    bus_wr(0, 1, 4'd0, 32'h00F0);        // 6 ticks through all ones
    bus_rd(0, 0, 4'd4, v); check("R9 count after max wrap", v, 32'd2);
    bus_rd(0, 0, 4'd0, v); check("R9 wrap flag bit14 only", v, 32'h4000);
    check("R9 no irq from wrap", {31'h0, irq32}, 32'h0);
  endtask

  task automatic t_presc;
    logic [31:0] v;
    bus_wr(0, 0, 4'd4, 32'd0);
    repeat (3) @(negedge clk);
    bus_wr(0, 0, 4'd0, 32'h01A4);
    bus_wr(0, 0, 4'd8, 32'd1000);
    bus_wr(0, 1, 4'd0, 32'h1);
    repeat (22) @(negedge clk);
    bus_wr(0, 1, 4'd0, 32'h0);           // 23 clocks at /8
    bus_rd(0, 0, 4'd4, v); check("R10 divide by 8", v, 32'd2);
    bus_rd(0, 0, 4'd0, v); check("R2 ctl readback", v, 32'h01A4);
    bus_wr(0, 0, 4'd0, 32'h0);
    bus_rd(0, 0, 4'd0, v); check("R6 ctl write zero", v, 32'h0);
    bus_wr(0, 0, 4'd8, 32'hFFFF_FFFF);
    bus_rd(0, 0, 4'd8, v); check("R8 cmp all ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    bus_wr(1, 0, 4'd4, 32'h0001_2345);
    bus_rd(1, 0, 4'd4, v); check("R8 R1 cmp truncated", v, 32'h0000_2345);
    bus_wr(1, 0, 4'd4, 32'd2);
    bus_wr(1, 0, 4'd0, 32'h0043);
    bus_wr(1, 1, 4'd0, 32'h1);
    repeat (1535) @(negedge clk);
    bus_wr(1, 1, 4'd0, 32'h0);           // 1536 clocks at /512
    bus_rd(1, 0, 4'd2, v); check("R10 R4 divide by 512 wrap", v, 32'd0);
    bus_rd(1, 0, 4'd0, v); check("R2 flag bit7", v, 32'h00C3);
    check("R6 irq narrow", {31'h0, irq16}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel_ch = '0; sel_st = '0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period();
    t_clear();
    t_sync();
    t_start_bits();
    t_wrap_max();
    t_presc();
    t_narrow();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule